// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will jump. It holds a table of two-bit saturating counters. The table is indexed by the word-aligned low bits of the fetch address XORed with a global register of recent branch outcomes. Branches that share address bits but sit in different global contexts therefore land in different counters.

The fetch stage presents a PC on the lookup port and receives, in the same cycle, a taken/not-taken guess and the table index that produced it. The fetch stage keeps that index with the branch. When the branch resolves, the index comes back on the update port together with the real outcome. The counter at that index is trained, and the outcome is shifted into the global history. History moves only on resolution, never on lookup. Target supply and speculative-history repair belong to other blocks.

Top module: `gpred_top`

## Requirements
- R1: After a synchronous active-low reset every counter holds weakly not-taken (01) and the history register is zero, so any lookup predicts not-taken with index equal to PC bits [11:2].
- R2: The prediction is bit 1 of the selected counter: counter values 10 and 11 predict taken (lk_taken=1), and 00 and 01 predict not-taken.
- R3: A taken update (up_taken=1) increments the counter at up_index by one and holds it at 11 once there, with no wrap to 00.
- R4: A not-taken update decrements the counter at up_index by one and holds it at 00 once there, with no wrap to 11.
- R5: A counter in a strong state (00 or 11) keeps its prediction after one opposite outcome, and flips only after a second consecutive opposite outcome.
- R6: The lookup index is PC bits [ALIGN_W+IDX_W-1:ALIGN_W] XOR the history, with history bit i folded onto index bit i mod IDX_W. PC bits outside that field have no effect.
- R7: Each update shifts up_taken into history bit 0 (1 = taken), moves every other bit up by one and drops the oldest bit.
- R8: An update changes only the counter named by up_index, whatever PC the lookup port holds in that cycle.
- R9: When a lookup and an update address the same counter in one cycle, the lookup returns the counter value from before the update.
- R10: In a cycle without up_valid, neither the history nor any counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W (32) | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| lk_index | output | IDX_W (10) | Table index used for this lookup |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_index | input | IDX_W (10) | Index saved from the branch's lookup |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check the history register on every cycle: its contents after reset, the shift on each update, and that it holds when no update arrives. They also check the one-step, non-wrapping move of a counter that is trained twice in a row through the same index. The scoreboard alone covers the rest. It shows the prediction read from the counter's top bit and the two-outcome hysteresis from strong states. It also shows that training stays confined to the named entry, that a colliding lookup sees the old value, and that the hashed index is correct for arbitrary PCs and history contents.

// File: rtl/gpred_pkg.sv
// Package: shared counter type, state codes and the saturating step rule
// for the global-history direction predictor.
package gpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Next counter value for a resolved outcome; sticks at both ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && (cur != CTR_STRONG_T))
            nxt = cur + 2'd1;
        else if (!taken && (cur != CTR_STRONG_NT))
            nxt = cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/gpred_hash.sv
// Module: gpred_hash
// Forms the table index from the aligned PC field and the global history.
// Assumes the caller has already stripped the alignment bits. History bits
// beyond IDX_W fold back onto the low index bits, so any HIST_W is legal.
module gpred_hash #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic [IDX_W-1:0]  pc_field,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  index
);

    // Fold every history bit onto index bit (i mod IDX_W).
    always_comb begin
        index = pc_field;
        for (int i = 0; i < HIST_W; i++) begin
            index[i % IDX_W] = index[i % IDX_W] ^ hist[i];
        end
    end

endmodule

// File: rtl/gpred_history.sv
// Module: gpred_history
// Global outcome shift register. Moves only on a resolved update: the new
// outcome enters bit 0 and the oldest bit leaves at the top.
// Assumes HIST_W >= 2.
module gpred_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_q
);

    // Clear on reset, otherwise shift the outcome in on each update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= {hist_q[HIST_W-2:0], outcome};
    end

endmodule

// File: rtl/gpred_table.sv
// Module: gpred_table
// Array of two-bit saturating counters with one asynchronous read port
// (lookup) and one read-modify-write port (training). A write lands at the
// clock edge, so a same-cycle read of that entry returns the old value.
module gpred_table
    import gpred_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_t             wr_old
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    // Combinational reads for lookup and for the training port.
    always_comb begin
        rd_ctr = ctr_q[rd_idx];
        wr_old = ctr_q[wr_idx];
    end

    // Reset all entries to weakly not-taken; train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_q[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(wr_old, wr_taken);
        end
    end

endmodule

// File: rtl/gpred_top.sv
// Module: gpred_top
// Correlating branch direction predictor. The lookup is combinational from
// lk_pc to lk_taken/lk_index. The update uses the index saved at lookup,
// trains that counter and shifts the outcome into the global history.
// Assumes PC_W > ALIGN_W + IDX_W and ALIGN_W >= 1.
module gpred_top
    import gpred_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 10,
    parameter int HIST_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_taken,
    output logic [IDX_W-1:0] lk_index,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_index,
    input  logic             up_taken
);

    localparam int FIELD_LO = ALIGN_W;
    localparam int FIELD_HI = ALIGN_W + IDX_W - 1;

    logic [IDX_W-1:0]  pc_field;
    logic [HIST_W-1:0] hist_q;
    ctr_t              rd_ctr;
    ctr_t              upd_old;
    logic              unused_pc_bits;

    // Select the aligned PC field; the remaining bits play no part in the index.
    always_comb begin
        pc_field       = lk_pc[FIELD_HI:FIELD_LO];
        unused_pc_bits = ^{lk_pc[PC_W-1:FIELD_HI+1], lk_pc[ALIGN_W-1:0]};
    end

    gpred_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) hash_i (
        .pc_field (pc_field),
        .hist     (hist_q),
        .index    (lk_index)
    );

    gpred_history #(.HIST_W(HIST_W)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist_q   (hist_q)
    );

    gpred_table #(.IDX_W(IDX_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_index),
        .rd_ctr   (rd_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_index),
        .wr_taken (up_taken),
        .wr_old   (upd_old)
    );

    // Direction guess is the counter's upper bit.
    always_comb lk_taken = rd_ctr[1];

endmodule

// File: rtl/gpred_chk.sv
// Module: gpred_chk
// Property checker bound into gpred_top. It watches the history register and
// the counter seen by the training port.
module gpred_chk #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic [IDX_W-1:0]  up_index,
    input logic              up_taken,
    input logic [HIST_W-1:0] hist_q,
    input logic [1:0]        upd_old
);

    logic past_ok;

    // Set once the previous cycle was out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_hist_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (hist_q == '0));

    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(up_valid)) |->
            (hist_q[0] == $past(up_taken)) &&
            (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(up_valid)) |-> $stable(hist_q));

    assert_sat_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(up_valid && up_taken) && (up_index == $past(up_index))) |->
            (($past(upd_old) == 2'b11) ? (upd_old == 2'b11)
                                       : (upd_old == $past(upd_old) + 2'd1)));

    assert_sat_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(up_valid && !up_taken) && (up_index == $past(up_index))) |->
            (($past(upd_old) == 2'b00) ? (upd_old == 2'b00)
                                       : (upd_old == $past(upd_old) - 2'd1)));

endmodule

bind gpred_top gpred_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_index (up_index),
    .up_taken (up_taken),
    .hist_q   (hist_q),
    .upd_old  (upd_old)
);

// File: tb/gpred_top_tb_top.sv
// Scoreboard bench: the driver computes the expected lookup result from a
// reference model and queues it; the monitor compares it mid-cycle.
module gpred_top_tb_top;

    localparam int CLK_P    = 10;
    localparam int IDX_W    = 10;
    localparam int HIST_W   = 10;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int WATCHDOG = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      lk_pc = '0;
    logic             lk_taken;
    logic [IDX_W-1:0] lk_index;
    logic             up_valid = 1'b0;
    logic [IDX_W-1:0] up_index = '0;
    logic             up_taken = 1'b0;

    typedef struct {
        string            tag;
        logic [IDX_W-1:0] idx;
        logic             pred;
    } exp_t;

    exp_t             sbq[$];
    logic [1:0]       mdl_ctr [DEPTH];
    logic [HIST_W-1:0] mdl_hist;
    int               n_chk = 0;
    int               n_err = 0;
    bit               done = 1'b0;

    gpred_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .lk_index (lk_index),
        .up_valid (up_valid),
        .up_index (up_index),
        .up_taken (up_taken)
    );

    always #(CLK_P/2) clk = ~clk;

    // PC whose lookup lands on entry e under the current model history;
    // junk in the upper and alignment bits must not matter (R6).
    function automatic logic [31:0] pc_at(input logic [IDX_W-1:0] e);
        return {20'hA5C3E, e ^ mdl_hist, 2'b11};
    endfunction

    // One cycle: drive, queue the expected lookup, then advance the model.
    task automatic step(input logic [31:0] pc, input logic uv,
                        input logic [IDX_W-1:0] ui, input logic ut, input string tag);
        exp_t e;
        @(negedge clk);
        lk_pc    = pc;
        up_valid = uv;
        up_index = ui;
        up_taken = ut;
        e.tag  = tag;
        e.idx  = pc[11:2] ^ mdl_hist;
        e.pred = mdl_ctr[e.idx][1];
        sbq.push_back(e);
        if (uv) begin
            if (ut && mdl_ctr[ui] != 2'b11)      mdl_ctr[ui] = mdl_ctr[ui] + 2'd1;
            else if (!ut && mdl_ctr[ui] != 2'b00) mdl_ctr[ui] = mdl_ctr[ui] - 2'd1;
            mdl_hist = {mdl_hist[HIST_W-2:0], ut};
        end
    endtask

    task automatic observe(input logic [IDX_W-1:0] e, input string tag);
        step(pc_at(e), 1'b0, '0, 1'b0, tag);
    endtask

    task automatic train(input logic [IDX_W-1:0] e, input logic t, input string tag);
        step(pc_at(e), 1'b1, e, t, tag);
    endtask

    // Monitor: compare each queued item a quarter period after the negedge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (lk_index !== e.idx || lk_taken !== e.pred) begin
                    n_err++;
                    $display("FAIL %s: index=%h taken=%b expected index=%h taken=%b",
                             e.tag, lk_index, lk_taken, e.idx, e.pred);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P*WATCHDOG);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 2'b01;
        mdl_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, index equals the raw PC field.
        step(32'h0000_1234, 1'b0, '0, 1'b0, "R1");
        step(32'hFFFF_FFFF, 1'b0, '0, 1'b0, "R1");
        step(32'h8000_0ffc, 1'b0, '0, 1'b0, "R1");

        // R3/R5/R9: climb entry 5 to strong taken and past it.
        observe(10'h005, "R2");
        train(10'h005, 1'b1, "R9");          // sees 01 while training
        observe(10'h005, "R3");               // 10 -> taken
        train(10'h005, 1'b1, "R9");
        train(10'h005, 1'b1, "R3");           // already 11, saturates
        observe(10'h005, "R3");
        train(10'h005, 1'b0, "R5");           // 11 -> 10
        observe(10'h005, "R5");               // still taken
        train(10'h005, 1'b0, "R5");           // 10 -> 01
        observe(10'h005, "R5");               // now not-taken
        // R4/R5: fall to strong not-taken and hold there.
        train(10'h005, 1'b0, "R4");
        train(10'h005, 1'b0, "R4");           // stays 00
        observe(10'h005, "R4");
        train(10'h005, 1'b1, "R5");           // 00 -> 01
        observe(10'h005, "R5");               // still not-taken

        // R8: training entry 0x20 leaves its neighbour alone.
        step(pc_at(10'h021), 1'b1, 10'h020, 1'b1, "R8");
        step(pc_at(10'h021), 1'b1, 10'h020, 1'b1, "R8");
        observe(10'h021, "R8");
        observe(10'h020, "R2");

        // R10: idle cycles, history and counters hold.
        for (int k = 0; k < 4; k++) step(32'h0000_0400 * k, 1'b0, '0, 1'b0, "R10");
        observe(10'h020, "R10");

        // R7/R6: long outcome stream drops old bits; PC=0 exposes the history.
        for (int k = 0; k < 13; k++) step(32'h0, 1'b1, 10'h300, (k % 3) == 0, "R7");
        step(32'h0, 1'b0, '0, 1'b0, "R7");
        step(32'h0000_0ABC, 1'b0, '0, 1'b0, "R6");

        // Mixed traffic, including colliding lookups and updates.
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step({lfsr, lfsr}, lfsr[3], lfsr[13:4] & 10'h03F, lfsr[0] | lfsr[7],
                 lfsr[0] ? "R3" : "R4");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule